// File: doc/BRIEF.md
# UART Modem Handshake Registers

This block is the modem-handshake slice of a UART register set. A control register drives the two active-low handshake outputs: terminal-ready and request-to-send. Two auxiliary bits and a loopback switch sit in the same register. The four active-low modem inputs are clear-to-send, data-set-ready, ring and carrier-detect. Each passes through a two-flop synchronizer and is shown in a status register in active-high form. Beside each status bit sits a sticky change flag. An interrupt request goes high when its enable bit is set and any change flag is up.

In loopback the block turns the serial path back on itself. The transmit stream from the character engine is fed straight to the receive side. The external receive pin is ignored and the external transmit pin is held at idle-high. The four status bits then follow control bits instead of the pins, so software can exercise the whole status and interrupt path without a cable. Registers are reached through a plain strobe port: read data shows the addressed register in the same cycle, and a strobed read of the status register clears the change flags.

Top module: `uart_modem_ctl`

## Requirements
- R1: Writing control register (address 0) bit 0 sets `dtr_n` to the inverse of that bit on the clock edge of the write: 1 drives the pin low, 0 drives it high.
- R2: Control register bit 1 drives `rts_n` the same way: 1 drives it low, 0 drives it high.
- R3: In reset `tx_pin` is 1 whatever `tx_core` is. After reset `dtr_n` and `rts_n` are 1, and the control, status (with all inputs high) and enable registers read 0.
- R4: Status register (address 1) bits are active-high images of the inputs: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring, bit 7 carrier-detect. Each shows a pin change after exactly two clock edges.
- R5: Status bits 0, 1 and 3 flag any change of clear-to-send, data-set-ready and carrier-detect. A flag is set on the third edge after the pin change and stays set until cleared.
- R6: Status bit 2 is set only when the ring input goes from active (low) to inactive (high). A ring pin falling sets no flag.
- R7: A strobed read (`reg_rd`) of address 1 clears bits 3:0 at that edge. A change that lands on the same edge stays set.
- R8: `irq` is 1 exactly while enable register (address 2) bit 0 is 1 and any of status bits 3:0 is 1. Clearing the enable leaves the flags latched.
- R9: With control bit 4 set (loopback), `tx_pin` is held at 1, `rx_core` follows `tx_core`, and `rx_pin` has no effect.
- R10: In loopback the status bits come from control bits with no synchronizer delay: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2, carrier-detect from bit 3. Their changes set the flags of R5 and R6 one edge later, and the modem pins are ignored.
- R11: Out of loopback `tx_pin` equals `tx_core` and `rx_core` equals `rx_pin`.
- R12: The control register reads back bits 4:0 with the upper bits 0. The enable register keeps only bit 0. Address 3 reads 0. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags on address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, same cycle |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring input, active low |
| dcd_n | input | 1 | Carrier-detect input, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| irq | output | 1 | Modem status interrupt request |
| tx_core | input | 1 | Serial stream from the transmitter |
| tx_pin | output | 1 | External serial transmit line |
| rx_pin | input | 1 | External serial receive line |
| rx_core | output | 1 | Serial stream to the receiver |

## Verification
A modem pin change shows in the status bits after two clock edges, and its change flag and `irq` after three. A control write, and the flag clear of a strobed read, take effect on one edge. Loopback status follows the control write edge with no delay, and its flags follow one edge after that. The serial muxing has no register. Stimulus is applied at a falling edge, and each result is read at the falling edge where it is due. Delayed results are also read one falling edge early, where the old value must still show.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;
    localparam int CTL_W  = 5;
    localparam int LINES  = 4;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd2;

    // control register bit positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_AUX1 = 2;
    localparam int CTL_AUX2 = 3;
    localparam int CTL_LOOP = 4;

    // change-flag positions inside the status register
    localparam int DLT_CTS = 0;
    localparam int DLT_DSR = 1;
    localparam int DLT_RI  = 2;
    localparam int DLT_DCD = 3;

    // active-high modem line state; cts is bit 0
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    function automatic mdm_lines_t loop_lines(input logic [CTL_W-1:0] ctl);
        mdm_lines_t l;
        l.cts = ctl[CTL_RTS];
        l.dsr = ctl[CTL_DTR];
        l.ri  = ctl[CTL_AUX1];
        l.dcd = ctl[CTL_AUX2];
        return l;
    endfunction

    function automatic logic [REG_DW-1:0] pack_status(input mdm_lines_t l,
                                                      input logic [LINES-1:0] d);
        return {l.dcd, l.ri, l.dsr, l.cts, d};
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int   W       = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] src;
        if (s == 0) begin : g_first
            assign src = d;
        end else begin : g_next
            assign src = chain[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= {W{RST_VAL}};
            else     chain[s] <= src;
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mdm_lines_t       cur,
    input  logic             clr,
    output logic [LINES-1:0] delta
);
    mdm_lines_t       prev;
    logic [LINES-1:0] hit;

    always_comb begin
        hit          = '0;
        hit[DLT_CTS] = cur.cts ^ prev.cts;
        hit[DLT_DSR] = cur.dsr ^ prev.dsr;
        hit[DLT_RI]  = prev.ri & ~cur.ri;   // ring going inactive only
        hit[DLT_DCD] = cur.dcd ^ prev.dcd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            delta <= '0;
        end else begin
            prev  <= cur;
            delta <= (clr ? '0 : delta) | hit;  // new change beats clear
        end
    end
endmodule

// File: rtl/mdm_loop.sv
module mdm_loop (
    input  logic rst,
    input  logic loop_en,
    input  logic tx_core,
    input  logic rx_pin,
    output logic tx_pin,
    output logic rx_core
);
    always_comb begin
        tx_pin  = (rst || loop_en) ? 1'b1 : tx_core;
        rx_core = loop_en ? tx_core : rx_pin;
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              irq,
    input  logic              tx_core,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rx_core
);
    logic [CTL_W-1:0] ctl_q;
    logic             ien_q;
    logic [LINES-1:0] pin_raw;
    logic [LINES-1:0] pin_s;
    mdm_lines_t       pin_lines;
    mdm_lines_t       cur;
    logic [LINES-1:0] delta_q;
    logic             stat_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ien_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: ctl_q <= reg_wdata[CTL_W-1:0];
                ADDR_IEN:  ien_q <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    assign pin_raw = {dcd_n, ri_n, dsr_n, cts_n};

    mdm_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign pin_lines = mdm_lines_t'(~pin_s);
    assign cur       = ctl_q[CTL_LOOP] ? loop_lines(ctl_q) : pin_lines;
    assign stat_clr  = reg_rd && (reg_addr == ADDR_STAT);

    mdm_delta i_delta (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .clr   (stat_clr),
        .delta (delta_q)
    );

    mdm_loop i_loop (
        .rst     (rst),
        .loop_en (ctl_q[CTL_LOOP]),
        .tx_core (tx_core),
        .rx_pin  (rx_pin),
        .tx_pin  (tx_pin),
        .rx_core (rx_core)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[CTL_W-1:0] = ctl_q;
            ADDR_STAT: reg_rdata = pack_status(cur, delta_q);
            ADDR_IEN:  reg_rdata[0] = ien_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign dtr_n = ~ctl_q[CTL_DTR];
    assign rts_n = ~ctl_q[CTL_RTS];
    assign irq   = ien_q & (|delta_q);

endmodule

// File: rtl/mdm_chk.sv
module mdm_chk
    import mdm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              dtr_n,
    input logic              rts_n,
    input logic              tx_pin,
    input logic [CTL_W-1:0]  ctl_q,
    input logic [LINES-1:0]  delta_q
);
    // R1
    dtr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CTRL) |=> (dtr_n == !$past(reg_wdata[CTL_DTR])));

    // R2
    rts_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CTRL) |=> (rts_n == !$past(reg_wdata[CTL_RTS])));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_addr == ADDR_STAT) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R9
    loop_tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q[CTL_LOOP] |-> tx_pin);

    // R3
    always_comb begin
        if (rst === 1'b1) begin
            rst_tx_idle_chk: assert (tx_pin === 1'b1);
        end
    end
endmodule

bind uart_modem_ctl mdm_chk i_mdm_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .tx_pin    (tx_pin),
    .ctl_q     (ctl_q),
    .delta_q   (delta_q)
);

// File: tb/test_uart_modem_ctl.sv
`timescale 1ns/100ps
module test_uart_modem_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic dtr_n, rts_n, irq;
    logic tx_core = 1'b1, rx_pin = 1'b1;
    logic tx_pin, rx_core;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    uart_modem_ctl i_uart_modem_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq),
        .tx_core(tx_core), .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_core(rx_core)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        rd(2'd1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        tx_core = 1'b0;
        step(3);
        chk("R3 tx idle in reset", {7'd0, tx_pin}, 8'h01);
        rst = 1'b0;
        tx_core = 1'b1;
        step(1);
        chk("R3 dtr_n after reset", {7'd0, dtr_n}, 8'h01);
        chk("R3 rts_n after reset", {7'd0, rts_n}, 8'h01);
        peek(2'd0, d); chk("R3 ctrl reset", d, 8'h00);
        peek(2'd2, d); chk("R3 ien reset", d, 8'h00);
        step(3);
        peek(2'd1, d); chk("R3 status reset", d, 8'h00);
    endtask

    task automatic t_ctrl_pins();
        wr(2'd0, 8'h01);
        chk("R1 dtr low", {7'd0, dtr_n}, 8'h00);
        chk("R2 rts stays high", {7'd0, rts_n}, 8'h01);
        wr(2'd0, 8'h02);
        chk("R1 dtr high", {7'd0, dtr_n}, 8'h01);
        chk("R2 rts low", {7'd0, rts_n}, 8'h00);
        wr(2'd0, 8'h00);
        chk("R2 rts high", {7'd0, rts_n}, 8'h01);
    endtask

    task automatic t_status();
        logic [7:0] d;
        clear_flags();
        @(negedge clk); cts_n = 1'b0;
        step(1); peek(2'd1, d); chk("R4 one edge not yet", d, 8'h00);
        step(1); peek(2'd1, d); chk("R4 cts at bit4", d, 8'h10);
        step(1); peek(2'd1, d); chk("R5 cts flag", d, 8'h11);
        clear_flags();
        peek(2'd1, d); chk("R7 read clears flags", d, 8'h10);
        dsr_n = 1'b0; dcd_n = 1'b0;
        step(2); peek(2'd1, d); chk("R4 dsr dcd bits", d, 8'hB0);
        step(1); peek(2'd1, d); chk("R5 dsr dcd flags", d, 8'hBA);
        step(4); peek(2'd1, d); chk("R5 flags sticky", d, 8'hBA);
        clear_flags();
        cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1;
        step(3); peek(2'd1, d); chk("R5 release flags", d, 8'h0B);
        clear_flags();
        peek(2'd1, d); chk("R7 cleared", d, 8'h00);
    endtask

    task automatic t_ring();
        logic [7:0] d;
        @(negedge clk); ri_n = 1'b0;
        step(2); peek(2'd1, d); chk("R4 ring bit6", d, 8'h40);
        step(2); peek(2'd1, d); chk("R6 no flag on ring active", d, 8'h40);
        ri_n = 1'b1;
        step(2); peek(2'd1, d); chk("R6 not yet", d, 8'h00);
        step(1); peek(2'd1, d); chk("R6 trailing edge flag", d, 8'h04);
        clear_flags();
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(2'd2, 8'h01);
        chk("R8 idle no irq", {7'd0, irq}, 8'h00);
        cts_n = 1'b0;
        step(2); chk("R8 irq not yet", {7'd0, irq}, 8'h00);
        step(1); chk("R8 irq raised", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h00);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);
        peek(2'd1, d); chk("R8 flag kept while masked", d, 8'h11);
        wr(2'd2, 8'h01);
        chk("R8 irq back", {7'd0, irq}, 8'h01);
        clear_flags();
        chk("R8 irq drops after clear", {7'd0, irq}, 8'h00);
        cts_n = 1'b1;
        step(3); chk("R8 irq on release", {7'd0, irq}, 8'h01);
        clear_flags();
        wr(2'd2, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        @(negedge clk); cts_n = 1'b0;
        step(1);
        rd(2'd1, d);
        chk("R7 read before flag", d, 8'h10);
        peek(2'd1, d); chk("R7 same-edge change kept", d, 8'h11);
        clear_flags();
        cts_n = 1'b1;
        step(3);
        clear_flags();
    endtask

    task automatic t_loop_serial();
        logic [7:0] d;
        wr(2'd0, 8'h10);
        tx_core = 1'b0; rx_pin = 1'b1;
        #1 chk("R9 tx pin held", {7'd0, tx_pin}, 8'h01);
        chk("R9 rx follows tx low", {7'd0, rx_core}, 8'h00);
        tx_core = 1'b1; rx_pin = 1'b0;
        #1 chk("R9 rx follows tx high", {7'd0, rx_core}, 8'h01);
        rx_pin = 1'b1;
        cts_n = 1'b0; dcd_n = 1'b0;
        step(4); peek(2'd1, d); chk("R10 pins ignored", d, 8'h00);
        cts_n = 1'b1; dcd_n = 1'b1;
        step(3);
    endtask

    task automatic t_loop_status();
        logic [7:0] d;
        wr(2'd0, 8'h12);
        peek(2'd1, d); chk("R10 rts to cts", d, 8'h10);
        step(1); peek(2'd1, d); chk("R10 cts flag", d, 8'h11);
        clear_flags();
        wr(2'd0, 8'h1D);
        peek(2'd1, d); chk("R10 dtr aux1 aux2 map", d, 8'hE0);
        chk("R1 dtr in loopback", {7'd0, dtr_n}, 8'h00);
        step(1); peek(2'd1, d); chk("R10 flags", d, 8'hEB);
        clear_flags();
        wr(2'd0, 8'h19);
        step(1); peek(2'd1, d); chk("R6 loop ring trailing", d, 8'hA4);
        clear_flags();
        wr(2'd0, 8'h00);
        peek(2'd1, d); chk("R10 exit loop status", d, 8'h00);
        step(1); peek(2'd1, d); chk("R10 exit flags", d, 8'h0A);
        clear_flags();
        tx_core = 1'b0; rx_pin = 1'b0;
        #1 chk("R11 tx pin follows", {7'd0, tx_pin}, 8'h00);
        chk("R11 rx core follows", {7'd0, rx_core}, 8'h00);
        rx_pin = 1'b1;
        #1 chk("R11 rx core high", {7'd0, rx_core}, 8'h01);
        tx_core = 1'b1;
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(2'd0, 8'hFF);
        peek(2'd0, d); chk("R12 ctrl readback", d, 8'h1F);
        wr(2'd0, 8'h00);
        step(2);
        clear_flags();
        wr(2'd2, 8'hFE);
        peek(2'd2, d); chk("R12 ien bit0 only", d, 8'h00);
        wr(2'd2, 8'hFF);
        peek(2'd2, d); chk("R12 ien readback", d, 8'h01);
        wr(2'd2, 8'h00);
        peek(2'd3, d); chk("R12 addr3 zero", d, 8'h00);
        wr(2'd1, 8'hFF);
        step(1);
        peek(2'd1, d); chk("R12 status write ignored", d, 8'h00);
        chk("R12 no irq from status write", {7'd0, irq}, 8'h00);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(5.0 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_ctrl_pins();
        t_status();
        t_ring();
        t_irq();
        t_collision();
        t_loop_serial();
        t_loop_status();
        t_regmap();
        report();
        $finish;
    end
endmodule